// File: doc/BRIEF.md
# Programming Pulse-Count Guard

This block watches a three-wire serial memory interface alongside the normal instruction front-end. It counts rising edges of the serial clock from the start bit until chip select drops. When the decoded instruction is one that programs the array, the block compares that count with the exact count the instruction needs in the current organisation. It then either grants execution or vetoes the command. A stray extra clock pulse, for example a glitch on the clock wire, shifts the address and data by one bit. The count check catches this, so a misaligned command never reaches the array.

Serial inputs are sampled by a fast system clock `clk` and are assumed to be already synchronised to it. The front-end reports the decoded instruction with a one-cycle `cmd_valid` strobe. The block answers with a one-cycle `exec_en` or `reject` pulse after chip select falls. There is no data stream here, so every pin is a plain control or status signal.

Top module: `pcg_top`

## Requirements
- R1: Counting starts at the first rising `ser_clk` edge seen with `ser_din`=1 while `chip_sel` is high, and that edge counts as 1. Earlier rising edges with `ser_din`=0 are not counted. The count ends when `chip_sel` falls.
- R2: For WRITE (`cmd_class`=2) and WRAL (`cmd_class`=5), the required count is 18 when `org_x16`=0 and 25 when `org_x16`=1.
- R3: For ERASE (`cmd_class`=3) and ERAL (`cmd_class`=4), the required count is 10 when `org_x16`=0 and 9 when `org_x16`=1.
- R4: For a programming class, the block decides in the clock cycle after the `clk` edge that sees `chip_sel` fall. If the count equals the required count, `exec_en` is high for that cycle; otherwise `reject` is high for that cycle.
- R5: If the latched class is READ (1), EWEN (6), EWDS (7), or no class was strobed (0), neither output pulses.
- R6: The count saturates at 2^CNT_W-1 (63 by default) and never wraps. A long burst therefore cannot alias to a valid count.
- R7: `exec_en` and `reject` are never high together.
- R8: Each verdict pulse lasts exactly one `clk` cycle.
- R9: `org_x16` is sampled at the start bit. Later changes during the same command do not affect the verdict.
- R10: `cmd_class` is latched on each `cmd_valid` cycle, and the last value strobed before `chip_sel` falls is the one used. The latch clears when `chip_sel` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel | input | 1 | Serial chip select, active high |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data input (used only to find the start bit) |
| org_x16 | input | 1 | Organisation: 1 = 16-bit words, 0 = 8-bit bytes |
| cmd_valid | input | 1 | One-cycle strobe: instruction decode complete |
| cmd_class | input | 3 | Decoded instruction class, valid with `cmd_valid` |
| exec_en | output | 1 | One-cycle grant for a correctly counted programming command |
| reject | output | 1 | One-cycle veto for a miscounted programming command |

## Verification
The assertions assume that `chip_sel`, `ser_clk` and `ser_din` are synchronous to `clk`. They also assume that each serial clock level is held for at least one `clk` cycle, so no serial edge is lost between samples. The bench drives every serial level for two `clk` cycles and changes inputs only on the falling edge of `clk`. It pulses `cmd_valid` while chip select is high. It always leaves chip select low for several cycles between commands, so no verdict from one command overlaps the next.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_READ  = 3'd1,
    CLS_WRITE = 3'd2,
    CLS_ERASE = 3'd3,
    CLS_ERAL  = 3'd4,
    CLS_WRAL  = 3'd5,
    CLS_EWEN  = 3'd6,
    CLS_EWDS  = 3'd7
  } cls_e;

  function automatic logic cls_programs(input cls_e c);
    return (c == CLS_WRITE) || (c == CLS_ERASE) || (c == CLS_ERAL) || (c == CLS_WRAL);
  endfunction

  function automatic logic cls_has_data(input cls_e c);
    return (c == CLS_WRITE) || (c == CLS_WRAL);
  endfunction
endpackage

// File: rtl/pcg_edges.sv
module pcg_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel,
  input  logic ser_clk,
  output logic clk_rise,
  output logic sel_fall
);
  logic sel_q, sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      sel_q  <= chip_sel;
      sclk_q <= ser_clk;
    end
  end

  // serial edges only matter while the device is selected
  assign clk_rise = ser_clk & ~sclk_q & chip_sel;
  assign sel_fall = sel_q & ~chip_sel;
endmodule

// File: rtl/pcg_counter.sv
module pcg_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_rise,
  input  logic             sel_fall,
  input  logic             ser_din,
  input  logic             org_x16,
  output logic [CNT_W-1:0] cnt,
  output logic             org_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
      org_q <= 1'b0;
    end else if (sel_fall) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (clk_rise) begin
      if (!armed) begin
        if (ser_din) begin
          armed <= 1'b1;
          cnt   <= CNT_W'(1);
          org_q <= org_x16;
        end
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pcg_verdict.sv
module pcg_verdict
  import pcg_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int OP_W      = 2,
  parameter int ADDR_W_8  = 7,
  parameter int ADDR_W_16 = 6,
  parameter int DATA_W_8  = 8,
  parameter int DATA_W_16 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_fall,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_class,
  input  logic [CNT_W-1:0] cnt,
  input  logic             org_q,
  output logic             exec_en,
  output logic             reject
);
  localparam int CTL_8  = 1 + OP_W + ADDR_W_8;
  localparam int CTL_16 = 1 + OP_W + ADDR_W_16;
  localparam logic [CNT_W-1:0] NEED_CTL_8   = CNT_W'(CTL_8);
  localparam logic [CNT_W-1:0] NEED_CTL_16  = CNT_W'(CTL_16);
  localparam logic [CNT_W-1:0] NEED_DATA_8  = CNT_W'(CTL_8 + DATA_W_8);
  localparam logic [CNT_W-1:0] NEED_DATA_16 = CNT_W'(CTL_16 + DATA_W_16);

  cls_e             cls_q;
  logic [CNT_W-1:0] need;

  always_comb begin
    if (cls_has_data(cls_q)) need = org_q ? NEED_DATA_16 : NEED_DATA_8;
    else                     need = org_q ? NEED_CTL_16  : NEED_CTL_8;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q   <= CLS_NONE;
      exec_en <= 1'b0;
      reject  <= 1'b0;
    end else begin
      exec_en <= 1'b0;
      reject  <= 1'b0;
      if (sel_fall) begin
        cls_q <= CLS_NONE;
        if (cls_programs(cls_q)) begin
          exec_en <= (cnt == need);
          reject  <= (cnt != need);
        end
      end else if (cmd_valid) begin
        cls_q <= cls_e'(cmd_class);
      end
    end
  end
endmodule

// File: rtl/pcg_top.sv
module pcg_top #(
  parameter int CNT_W     = 6,
  parameter int OP_W      = 2,
  parameter int ADDR_W_8  = 7,
  parameter int ADDR_W_16 = 6,
  parameter int DATA_W_8  = 8,
  parameter int DATA_W_16 = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_sel,
  input  logic       ser_clk,
  input  logic       ser_din,
  input  logic       org_x16,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_class,
  output logic       exec_en,
  output logic       reject
);
  logic             clk_rise, sel_fall, org_q;
  logic [CNT_W-1:0] cnt;

  pcg_edges u_edges (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .ser_clk(ser_clk),
    .clk_rise(clk_rise), .sel_fall(sel_fall)
  );

  pcg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clk_rise(clk_rise), .sel_fall(sel_fall),
    .ser_din(ser_din), .org_x16(org_x16), .cnt(cnt), .org_q(org_q)
  );

  pcg_verdict #(
    .CNT_W(CNT_W), .OP_W(OP_W), .ADDR_W_8(ADDR_W_8), .ADDR_W_16(ADDR_W_16),
    .DATA_W_8(DATA_W_8), .DATA_W_16(DATA_W_16)
  ) u_verdict (
    .clk(clk), .rst_n(rst_n), .sel_fall(sel_fall), .cmd_valid(cmd_valid),
    .cmd_class(cmd_class), .cnt(cnt), .org_q(org_q),
    .exec_en(exec_en), .reject(reject)
  );
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chip_sel,
  input logic             exec_en,
  input logic             reject,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_en && reject));

  assert_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en || reject) |-> ($past(chip_sel, 2) && !$past(chip_sel)));

  assert_exec_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> !exec_en);

  assert_reject_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !reject);

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && chip_sel) |=> (cnt == CNT_MAX));
endmodule

bind pcg_top pcg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel),
  .exec_en(exec_en), .reject(reject), .cnt(cnt)
);

// File: tb/pcg_top_tb_top.sv
module pcg_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_sel = 1'b0, ser_clk = 1'b0, ser_din = 1'b0, org_x16 = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_class = 3'd0;
  logic       exec_en, reject;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // expected outcome: 0 none, 1 exec, 2 reject
  typedef struct { int outcome; string req; } exp_t;
  exp_t sb_q[$];
  event cmd_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcg_top dut_i (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .ser_clk(ser_clk),
    .ser_din(ser_din), .org_x16(org_x16), .cmd_valid(cmd_valid),
    .cmd_class(cmd_class), .exec_en(exec_en), .reject(reject)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic half_bit();
    repeat (2) @(negedge clk);
  endtask

  // lead: zero bits before start; pulses: edges from start bit onward
  task automatic send(input int cls, input bit org, input int lead, input int pulses,
                      input int expect_out, input string req, input bit flip_org = 1'b0,
                      input int cls2 = -1);
    sb_q.push_back('{expect_out, req});
    @(negedge clk);
    org_x16  = org;
    chip_sel = 1'b1;
    half_bit();
    for (int i = 0; i < lead + pulses; i++) begin
      ser_din = (i == lead);
      half_bit();
      ser_clk = 1'b1;
      half_bit();
      ser_clk = 1'b0;
      if (i == lead && flip_org) org_x16 = ~org;
      if (i == lead + 2) begin
        cmd_valid = 1'b1; cmd_class = 3'(cls);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (cls2 >= 0) begin
          @(negedge clk);
          cmd_valid = 1'b1; cmd_class = 3'(cls2);
          @(negedge clk);
          cmd_valid = 1'b0;
        end
      end
    end
    ser_din = 1'b0;
    half_bit();
    chip_sel = 1'b0;
    -> cmd_end;
    repeat (6) @(negedge clk);
  endtask

  // monitor: pops expectation, samples the verdict cycle and the one after
  initial begin
    forever begin
      @(cmd_end);
      @(negedge clk);
      begin
        exp_t e;
        int   got;
        e = sb_q.pop_front();
        got = exec_en ? 1 : (reject ? 2 : 0);
        if (exec_en && reject) got = 3;
        check(e.req, got, e.outcome);
        @(negedge clk);
        check({e.req, " R8 pulse width"}, int'(exec_en) + int'(reject), 0);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset exec_en", int'(exec_en), 0);
    check("reset reject", int'(reject), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(2, 0, 0, 18, 1, "R2 write x8 exact");
    send(2, 0, 0, 19, 2, "R4 write x8 extra pulse");
    send(2, 0, 0, 17, 2, "R4 write x8 short");
    send(2, 1, 0, 25, 1, "R2 write x16 exact");
    send(2, 1, 0, 18, 2, "R2 write x16 with x8 count");
    send(5, 1, 0, 25, 1, "R2 wral x16 exact");
    send(5, 0, 0, 19, 2, "R2 wral x8 extra");
    send(3, 0, 0, 10, 1, "R3 erase x8 exact");
    send(3, 1, 0, 9,  1, "R3 erase x16 exact");
    send(4, 1, 0, 9,  1, "R3 eral x16 exact");
    send(4, 0, 0, 11, 2, "R3 eral x8 extra");
    send(1, 0, 0, 26, 0, "R5 read ignored");
    send(6, 1, 0, 9,  0, "R5 ewen ignored");
    send(7, 0, 0, 10, 0, "R5 ewds ignored");
    send(2, 0, 3, 18, 1, "R1 leading zeros not counted");
    send(2, 0, 0, 82, 2, "R6 long burst saturates");
    send(2, 1, 0, 25, 1, "R9 org held from start bit", 1'b1);
    send(6, 0, 0, 18, 1, "R10 last class wins", 1'b0, 2);
    send(2, 0, 0, 18, 1, "R10 latch cleared, write again");

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule